// File: doc/BRIEF.md
# Host Flash Command Sequencer

This block sits between a user and a 16-bit NOR flash device on a simple synchronous bus. A single request names an operation: word program, sector erase, chip erase, identifier read, entering or leaving the fast-program mode, erase suspend or erase resume. The block turns that request into the series of command writes the flash expects. Command word addresses are scaled to byte addresses for the bus width, so word 0x555 goes out as byte 0xAAA.

For program and erase operations, the block then reads the target address every cycle. It watches the toggle bit (data bit 6) and finishes when two reads in a row return the same value. A timeout value set by the user limits how many of those comparisons may fail. When the limit is reached, the operation ends with an error flag. Only one request is handled at a time. `busy_o` stays high until the single-cycle `done_o` pulse.

The bus is registered: read data for a read strobe in cycle t is presented on `bus_rdata_i` in cycle t+1.

Top module: `flash_cmd_seq`

## Requirements
- R1: Opcode 0 (program), with fast-program mode off, writes 0xAA@byte 0xAAA, 0x55@0x554, 0xA0@0xAAA, then the data at twice the word address. The block then polls.
- R2: Opcode 1 (sector erase) writes 0xAA@0xAAA, 0x55@0x554, 0x80@0xAAA, 0xAA@0xAAA, 0x55@0x554, then 0x30 at twice the sector word address. The block then polls that address.
- R3: Opcode 2 (chip erase) writes the same five-write prefix as R2, then 0x10@0xAAA. The block then polls the request address.
- R4: Opcode 4 writes 0xAA@0xAAA, 0x55@0x554, 0x20@0xAAA and turns fast-program mode on. While the mode is on, a program writes only 0xA0@0xAAA and then the data. Opcode 5 writes 0x00@0 and turns the mode off.
- R5: Opcode 6 writes 0xB0@0 and opcode 7 writes 0x30@0. Neither operation polls or issues any read.
- R6: Opcode 3 writes 0xAA@0xAAA, 0x55@0x554, 0x90@0xAAA, reads byte address 0 once, then writes 0xF0@0. The word that was read is held on `rdata_o` after done.
- R7: During polling, every read goes to the target byte address. Done comes with `err_o`=0 as soon as two consecutive reads agree in bit 6.
- R8: If the first max(`timeout_i`,1) comparisons of bit 6 all differ, done comes with `err_o`=1.
- R9: `busy_o` is high from the cycle after a request is accepted through the done cycle. A request made while busy is ignored and causes no bus writes.
- R10: After reset the block is idle: `busy_o`, `done_o` and both strobes are low. No strobe is asserted while the block is idle.
- R11: The write and read strobes are never high together, and `done_o` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, taken when not busy |
| op_i | input | 3 | Operation code (see R1 to R6) |
| addr_i | input | WAW (22) | Target word address |
| data_i | input | DW (16) | Program data |
| timeout_i | input | TW (16) | Maximum number of failed toggle comparisons |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Polling timeout, valid with done_o |
| rdata_o | output | DW (16) | Word captured by the identifier read |
| bus_addr_o | output | WAW+1 (23) | Bus byte address |
| bus_wdata_o | output | DW (16) | Bus write data |
| bus_we_o | output | 1 | Bus write strobe |
| bus_re_o | output | 1 | Bus read strobe |
| bus_rdata_i | input | DW (16) | Bus read data, one cycle after bus_re_o |

## Verification
The assertions check properties that must hold on every cycle:
- the two strobes never overlap;
- done is a one-cycle pulse;
- no strobe is asserted while the block is idle;
- the operation latched at acceptance does not change under a request made while busy;
- every identifier capture follows a read strobe.

The exact order, addresses and values of each command script are shown only by the bench scenarios. So are the switch into and out of fast-program mode, the identifier value and where polling ends. The bench compares logged bus writes against scripts it builds itself, and drives a flash model whose toggle bit flips a chosen number of times. This covers both sides of the timeout limit.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    OP_PROG    = 3'd0,
    OP_SECT    = 3'd1,
    OP_CHIP    = 3'd2,
    OP_ID      = 3'd3,
    OP_BYP_ON  = 3'd4,
    OP_BYP_OFF = 3'd5,
    OP_SUSP    = 3'd6,
    OP_RES     = 3'd7
  } op_e;

  typedef enum logic [1:0] {K_WR, K_RD, K_END} kind_e;

  localparam logic [11:0] ADR_U0 = 12'h555;
  localparam logic [11:0] ADR_U1 = 12'h2AA;
endpackage

// File: rtl/fcs_script.sv
module fcs_script
  import fcs_pkg::*;
#(
  parameter int WAW = 22,
  parameter int DW  = 16
) (
  input  op_e            op_i,
  input  logic           byp_i,
  input  logic [2:0]     step_i,
  input  logic [WAW-1:0] tgt_i,
  input  logic [DW-1:0]  data_i,
  output kind_e          kind_o,
  output logic [WAW-1:0] waddr_o,
  output logic [DW-1:0]  wdata_o
);
  localparam logic [WAW-1:0] A0 = WAW'(ADR_U0);
  localparam logic [WAW-1:0] A1 = WAW'(ADR_U1);

  always_comb begin
    kind_o  = K_WR;
    waddr_o = '0;
    wdata_o = '0;
    unique case (op_i)
      OP_PROG: begin
        if (byp_i) begin
          case (step_i)
            3'd0:    begin waddr_o = A0; wdata_o = DW'(8'hA0); end
            3'd1:    begin waddr_o = tgt_i; wdata_o = data_i; end
            default: kind_o = K_END;
          endcase
        end else begin
          case (step_i)
            3'd0:    begin waddr_o = A0; wdata_o = DW'(8'hAA); end
            3'd1:    begin waddr_o = A1; wdata_o = DW'(8'h55); end
            3'd2:    begin waddr_o = A0; wdata_o = DW'(8'hA0); end
            3'd3:    begin waddr_o = tgt_i; wdata_o = data_i; end
            default: kind_o = K_END;
          endcase
        end
      end
      OP_SECT, OP_CHIP: begin
        case (step_i)
          3'd0, 3'd3: begin waddr_o = A0; wdata_o = DW'(8'hAA); end
          3'd1, 3'd4: begin waddr_o = A1; wdata_o = DW'(8'h55); end
          3'd2:       begin waddr_o = A0; wdata_o = DW'(8'h80); end
          3'd5: begin
            if (op_i == OP_SECT) begin waddr_o = tgt_i; wdata_o = DW'(8'h30); end
            else begin waddr_o = A0; wdata_o = DW'(8'h10); end
          end
          default: kind_o = K_END;
        endcase
      end
      OP_ID: begin
        case (step_i)
          3'd0:    begin waddr_o = A0; wdata_o = DW'(8'hAA); end
          3'd1:    begin waddr_o = A1; wdata_o = DW'(8'h55); end
          3'd2:    begin waddr_o = A0; wdata_o = DW'(8'h90); end
          3'd3:    kind_o = K_RD;
          3'd4:    wdata_o = DW'(8'hF0);
          default: kind_o = K_END;
        endcase
      end
      OP_BYP_ON: begin
        case (step_i)
          3'd0:    begin waddr_o = A0; wdata_o = DW'(8'hAA); end
          3'd1:    begin waddr_o = A1; wdata_o = DW'(8'h55); end
          3'd2:    begin waddr_o = A0; wdata_o = DW'(8'h20); end
          default: kind_o = K_END;
        endcase
      end
      OP_BYP_OFF: if (step_i != 3'd0) kind_o = K_END;
      OP_SUSP: begin
        if (step_i == 3'd0) wdata_o = DW'(8'hB0);
        else kind_o = K_END;
      end
      OP_RES: begin
        if (step_i == 3'd0) wdata_o = DW'(8'h30);
        else kind_o = K_END;
      end
    endcase
  end
endmodule

// File: rtl/fcs_poll.sv
module fcs_poll #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] tmo_i,
  input  logic          bit_i,
  output logic          re_o,
  output logic          fin_o,
  output logic          err_o
);
  logic          act_q, rv_q, have_q, prev_q;
  logic [TW-1:0] cnt_q;
  logic [TW:0]   cnt_n;
  logic          cmp, same, limit;

  assign cnt_n = {1'b0, cnt_q} + 1'b1;
  assign cmp   = act_q & rv_q & have_q;
  assign same  = bit_i == prev_q;
  assign limit = cnt_n >= {1'b0, tmo_i};
  assign fin_o = cmp & (same | limit);
  assign err_o = cmp & ~same & limit;
  assign re_o  = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; rv_q <= 1'b0; have_q <= 1'b0; prev_q <= 1'b0; cnt_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1; rv_q <= 1'b0; have_q <= 1'b0; cnt_q <= '0;
    end else if (act_q) begin
      rv_q <= 1'b1;
      if (rv_q) begin
        prev_q <= bit_i;
        have_q <= 1'b1;
        if (have_q) cnt_q <= cnt_n[TW-1:0];
      end
      if (fin_o) act_q <= 1'b0;
    end
  end

  // R7
  no_fin_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> $past(re_o));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int WAW       = 22,
  parameter int DW        = 16,
  parameter int BUS_BYTES = 2,
  parameter int TW        = 16,
  parameter int TOG_BIT   = 6
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               req_i,
  input  logic [2:0]                         op_i,
  input  logic [WAW-1:0]                     addr_i,
  input  logic [DW-1:0]                      data_i,
  input  logic [TW-1:0]                      timeout_i,
  output logic                               busy_o,
  output logic                               done_o,
  output logic                               err_o,
  output logic [DW-1:0]                      rdata_o,
  output logic [WAW+$clog2(BUS_BYTES)-1:0]   bus_addr_o,
  output logic [DW-1:0]                      bus_wdata_o,
  output logic                               bus_we_o,
  output logic                               bus_re_o,
  input  logic [DW-1:0]                      bus_rdata_i
);
  localparam int SH = $clog2(BUS_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_RDW, S_POLL, S_DONE} st_e;

  st_e            st_q;
  op_e            op_q;
  logic [WAW-1:0] adr_q;
  logic [DW-1:0]  dat_q, rdata_q;
  logic [TW-1:0]  tmo_q;
  logic [2:0]     step_q;
  logic           byp_q, err_q;

  kind_e          kind;
  logic [WAW-1:0] s_addr;
  logic [DW-1:0]  s_data;
  logic           needs_poll, p_start, p_re, p_fin, p_err;

  fcs_script #(.WAW(WAW), .DW(DW)) script_i (
    .op_i(op_q), .byp_i(byp_q), .step_i(step_q), .tgt_i(adr_q), .data_i(dat_q),
    .kind_o(kind), .waddr_o(s_addr), .wdata_o(s_data)
  );

  assign needs_poll = op_q inside {OP_PROG, OP_SECT, OP_CHIP};
  assign p_start    = (st_q == S_RUN) && (kind == K_END) && needs_poll;

  fcs_poll #(.TW(TW)) poll_i (
    .clk_i, .rst_ni, .start_i(p_start), .tmo_i(tmo_q), .bit_i(bus_rdata_i[TOG_BIT]),
    .re_o(p_re), .fin_o(p_fin), .err_o(p_err)
  );

  assign bus_we_o    = (st_q == S_RUN) && (kind == K_WR);
  assign bus_re_o    = ((st_q == S_RUN) && (kind == K_RD)) | p_re;
  assign bus_addr_o  = {(st_q == S_POLL) ? adr_q : s_addr, {SH{1'b0}}};
  assign bus_wdata_o = s_data;
  assign busy_o      = st_q != S_IDLE;
  assign done_o      = st_q == S_DONE;
  assign err_o       = done_o & err_q;
  assign rdata_o     = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; op_q <= OP_PROG; adr_q <= '0; dat_q <= '0; tmo_q <= '0;
      step_q <= '0; byp_q <= 1'b0; err_q <= 1'b0; rdata_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_i) begin
          op_q <= op_e'(op_i); adr_q <= addr_i; dat_q <= data_i; tmo_q <= timeout_i;
          step_q <= '0; err_q <= 1'b0; st_q <= S_RUN;
        end
        S_RUN: begin
          unique case (kind)
            K_WR:  step_q <= step_q + 3'd1;
            K_RD:  begin step_q <= step_q + 3'd1; st_q <= S_RDW; end
            K_END: st_q <= needs_poll ? S_POLL : S_DONE;
            default: st_q <= S_DONE;
          endcase
        end
        S_RDW: begin rdata_q <= bus_rdata_i; st_q <= S_RUN; end
        S_POLL: if (p_fin) begin err_q <= p_err; st_q <= S_DONE; end
        S_DONE: begin
          if (op_q == OP_BYP_ON)  byp_q <= 1'b1;
          if (op_q == OP_BYP_OFF) byp_q <= 1'b0;
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R11
  no_we_re_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o));
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_we_o && !bus_re_o);
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && req_i |=> op_q == $past(op_q));
  // R6
  id_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_RDW |-> $past(bus_re_o));
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [21:0] addr_i = '0;
  logic [15:0] data_i = '0;
  logic [15:0] timeout_i = '0;
  logic        busy_o, done_o, err_o, bus_we_o, bus_re_o;
  logic [15:0] rdata_o, bus_wdata_o;
  logic [22:0] bus_addr_o;
  logic [15:0] rd_q = '0;

  flash_cmd_seq dut_i (
    .clk_i, .rst_ni, .req_i, .op_i, .addr_i, .data_i, .timeout_i,
    .busy_o, .done_o, .err_o, .rdata_o,
    .bus_addr_o, .bus_wdata_o, .bus_we_o, .bus_re_o, .bus_rdata_i(rd_q)
  );

  always #5 clk_i = ~clk_i;

  int total = 0, bad = 0, cyc = 0;
  logic [22:0] la [0:2047];
  logic [15:0] ld [0:2047];
  logic [22:0] ra [0:8191];
  int wn = 0, rn = 0;
  logic m_tog = 1'b0, m_id = 1'b0;
  int m_left = 0, m_load = 0;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (bus_we_o) begin
      la[wn] <= bus_addr_o; ld[wn] <= bus_wdata_o; wn <= wn + 1;
      m_left <= m_load;
      if (bus_wdata_o == 16'h0090) m_id <= 1'b1;
      else if (bus_wdata_o == 16'h00F0) m_id <= 1'b0;
    end
    if (bus_re_o) begin
      rd_q <= (m_id && bus_addr_o == 0) ? 16'h00BF : {9'h0, m_tog, 6'h0};
      if (m_left > 0) begin m_tog <= ~m_tog; m_left <= m_left - 1; end
      ra[rn] <= bus_addr_o; rn <= rn + 1;
    end
  end

  always @(posedge clk_i) if (cyc > 150000) begin
    bad = bad + 1; total = total + 1;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [22:0] ea [0:15];
  logic [15:0] ed [0:15];
  int en;
  logic byp_m = 1'b0;

  task automatic chk(input string req, input logic ok, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s: actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic ew(input logic [21:0] wa, input logic [15:0] d);
    ea[en] = {wa, 1'b0}; ed[en] = d; en++;
  endtask

  // op codes: 0 prog,1 sect,2 chip,3 id,4 byp on,5 byp off,6 susp,7 res
  task automatic run_op(input string req, input logic [2:0] op, input logic [21:0] wa,
                        input logic [15:0] d, input int k, input logic [15:0] t,
                        input logic exp_err, input logic poke);
    int ws, rs, w, bw, brd;
    logic got_err, poll;
    en = 0;
    case (op)
      3'd0: if (byp_m) begin ew(22'h555, 16'hA0); ew(wa, d); end
            else begin ew(22'h555, 16'hAA); ew(22'h2AA, 16'h55); ew(22'h555, 16'hA0); ew(wa, d); end
      3'd1, 3'd2: begin
        ew(22'h555, 16'hAA); ew(22'h2AA, 16'h55); ew(22'h555, 16'h80);
        ew(22'h555, 16'hAA); ew(22'h2AA, 16'h55);
        if (op == 3'd1) ew(wa, 16'h30); else ew(22'h555, 16'h10);
      end
      3'd3: begin ew(22'h555, 16'hAA); ew(22'h2AA, 16'h55); ew(22'h555, 16'h90); ew(22'h0, 16'hF0); end
      3'd4: begin ew(22'h555, 16'hAA); ew(22'h2AA, 16'h55); ew(22'h555, 16'h20); end
      3'd5: ew(22'h0, 16'h00);
      3'd6: ew(22'h0, 16'hB0);
      default: ew(22'h0, 16'h30);
    endcase
    poll = op <= 3'd2;
    @(negedge clk_i);
    m_load = k; timeout_i = t; ws = wn; rs = rn;
    op_i = op; addr_i = wa; data_i = d; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    chk({req, " R9 busy after accept"}, busy_o === 1'b1, busy_o, 1);
    if (poke) begin
      @(negedge clk_i);
      op_i = 3'd6; req_i = 1'b1;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    w = 0;
    while (done_o !== 1'b1 && w < 1000) begin @(negedge clk_i); w++; end
    got_err = err_o;
    chk({req, " R7 R8 done/err"}, w < 1000 && got_err === exp_err, got_err, exp_err);
    @(negedge clk_i);
    chk({req, " R11 done pulse"}, done_o === 1'b0 && busy_o === 1'b0, done_o, 0);
    bw = -1;
    if (wn - ws != en) bw = 99;
    else for (int i = 0; i < en; i++) if (bw < 0 && (la[ws+i] !== ea[i] || ld[ws+i] !== ed[i])) bw = i;
    chk({req, " script R1 R2 R3 R4 R5 R6 R9"}, bw < 0, (bw < 0 || bw == 99) ? wn - ws : ld[ws+bw],
        (bw < 0 || bw == 99) ? en : ed[bw]);
    brd = 0;
    if (poll) begin
      for (int i = rs; i < rn; i++) if (ra[i] !== {wa, 1'b0}) brd++;
      if (!exp_err && rn - rs < k + 2) brd++;
    end else if (op == 3'd3) begin
      if (rn - rs != 1 || ra[rs] !== 23'h0) brd++;
    end else if (rn != rs) brd++;
    chk({req, " R5 R6 R7 read addresses"}, brd == 0, brd, 0);
    if (op == 3'd3) chk({req, " R6 id word"}, rdata_o === 16'h00BF, rdata_o, 16'h00BF);
    if (op == 3'd4) byp_m = 1'b1;
    if (op == 3'd5) byp_m = 1'b0;
  endtask

  initial begin
    #1;
    chk("R10 reset idle", busy_o === 0 && done_o === 0 && bus_we_o === 0 && bus_re_o === 0, busy_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R10 idle after reset", busy_o === 0 && bus_we_o === 0 && bus_re_o === 0, busy_o, 0);

    for (int k = 0; k <= 6; k++) begin
      run_op("R1 prog", 3'd0, 22'h000123 + 22'(k), 16'h1234 + 16'(k), k, 16'd4, k >= 4, 1'b0);
      run_op("R2 sect", 3'd1, 22'h3F8000 - 22'(k * 16'h800), 16'h0, k, 16'd4, k >= 4, 1'b0);
    end
    run_op("R3 chip", 3'd2, 22'h0, 16'h0, 3, 16'd4, 1'b0, 1'b1);
    run_op("R3 chip tmo", 3'd2, 22'h0, 16'h0, 9, 16'd8, 1'b1, 1'b0);
    run_op("R8 tmo0 ok", 3'd0, 22'h3FFFFF, 16'hFFFE, 0, 16'd0, 1'b0, 1'b0);
    run_op("R8 tmo0 err", 3'd0, 22'h3FFFFF, 16'h0001, 1, 16'd0, 1'b1, 1'b0);
    run_op("R6 id", 3'd3, 22'h1, 16'h0, 0, 16'd4, 1'b0, 1'b0);
    run_op("R4 byp on", 3'd4, 22'h0, 16'h0, 0, 16'd4, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++)
      run_op("R4 byp prog", 3'd0, 22'(i * 3), 16'h0101 * 16'(i + 1), i, 16'd4, 1'b0, 1'b0);
    run_op("R4 byp prog tmo", 3'd0, 22'h7, 16'h4567, 5, 16'd2, 1'b1, 1'b0);
    run_op("R4 byp off", 3'd5, 22'h0, 16'h0, 0, 16'd4, 1'b0, 1'b0);
    run_op("R4 prog after off", 3'd0, 22'h10, 16'h89AB, 1, 16'd4, 1'b0, 1'b0);
    run_op("R5 susp", 3'd6, 22'h55, 16'h0, 0, 16'd4, 1'b0, 1'b0);
    run_op("R5 res", 3'd7, 22'h55, 16'h0, 0, 16'd4, 1'b0, 1'b0);
    run_op("R9 sect poke", 3'd1, 22'h8000, 16'h0, 2, 16'd4, 1'b0, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule